// File: doc/BRIEF.md
# Two-Bank Interleaved Read Controller

This block sits between a processor port and two independent word-wide memory banks. Even word addresses are stored in one bank and odd word addresses in the other. Each bank has its own address bus, so both banks can work at the same time. Each bank has a fixed read latency of `LAT` cycles and accepts one command per cycle.

When the processor reads address A, the controller reads A from its bank if it does not already hold that word. In the same cycle it starts a look-ahead read of A+1 on the other bank, without waiting for a request. A small buffer keeps one tagged word per bank. A later read that matches a finished or in-flight look-ahead is answered from the buffer. A stream that alternates between banks therefore avoids most of the bank latency. Repeated reads to one bank still pay the full latency. Writes go straight to the bank. Two saturating counters record how many reads hit the buffer and how many missed.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: Bit 0 of the word address selects the bank (0 = bank 0, 1 = bank 1). The bank row driven on that bank's address bus is address bits [AW-1:1].
- R2: A read miss whose look-ahead word is not yet held drives a read on both banks in the acceptance cycle.
- R3: An accepted read of address A drives a read of A+1 (modulo 2^AW) on the other bank in the acceptance cycle. This does not happen if that bank already holds, or is already fetching, A+1.
- R4: A read that misses the buffer raises `rsp_valid` exactly LAT+1 cycles after the acceptance cycle, with the bank's data. `req_ready` stays low until then.
- R5: A read that matches a look-ahead word whose data has already arrived raises `rsp_valid` in the cycle after acceptance.
- R6: A read that matches a look-ahead still in flight raises `rsp_valid` in the cycle after that data arrives. This is sooner than a miss.
- R7: Consecutive reads to the same bank, at different addresses, each miss and each take the full latency of R4.
- R8: A write is accepted in one cycle. It drives a write on the target bank with the row and data, starts no read on either bank and gives no response. A buffered word at that address is dropped, so a later read of it misses and returns the new data.
- R9: Each read adds one to either the hit counter or the miss counter, never both. Each counter is CW bits wide (default 16) and holds at all-ones once it gets there.
- R10: After reset, `req_ready` is 1, `rsp_valid` is 0, both counters are 0, no bank command is driven, and the buffer is empty.
- R11: A read that misses on a bank whose look-ahead is still in flight replaces that look-ahead with the real address. The response carries the data of the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | DW | Read data |
| b0_rd | output | 1 | Bank 0 read strobe |
| b0_wr | output | 1 | Bank 0 write strobe |
| b0_addr | output | AW-1 | Bank 0 row address |
| b0_wdata | output | DW | Bank 0 write data |
| b0_rdata | input | DW | Bank 0 read data, LAT cycles after the strobe |
| b1_rd | output | 1 | Bank 1 read strobe |
| b1_wr | output | 1 | Bank 1 write strobe |
| b1_addr | output | AW-1 | Bank 1 row address |
| b1_wdata | output | DW | Bank 1 write data |
| b1_rdata | input | DW | Bank 1 read data, LAT cycles after the strobe |
| hit_count | output | CW | Saturating count of buffer hits |
| miss_count | output | CW | Saturating count of buffer misses |

## Verification
The read path is driven with four kinds of stream:
- A strictly alternating ascending stream. It separates hits on finished look-aheads (answered next cycle) from hits on look-aheads still in flight (answered when their data lands).
- Runs of reads to the same bank. These must show the full miss latency every time.
- A jump to the bank holding a pending look-ahead. This shows that the look-ahead is cancelled and the requested word is returned.
- A repeated address and a wrap from the top address to zero. These check tag matching and the modulo next address.

Writes between reads show that a buffered word is dropped. Long hit and miss runs drive the counters into saturation.

// File: rtl/ilv_pkg.sv
// Shared definitions for the two-bank interleaved read controller.
package ilv_pkg;
    // Number of banks; the design is written for exactly two.
    localparam int NBANK = 2;

    // Processor-side sequencing state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ilv_state_e;
endpackage

// File: rtl/ilv_sat_cnt.sv
// Saturating up-counter.
// Counts one per cycle with inc high and holds once it is all-ones.
// Assumes a synchronous active-low reset.
module ilv_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q;

    // Advance the count unless it is already saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != MAXV)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign q = cnt_q;

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV) |=> (cnt_q == MAXV));

    p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt_q != MAXV)) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/ilv_bank_slot.sv
// One buffer slot per bank.
// Records the row of the last read sent to its bank, counts down the fixed
// bank latency and captures the returned word.
// Assumes the bank returns data exactly LAT cycles after a read strobe and
// that LAT >= 1. A newer issue replaces any older one, and the data of the
// replaced read is never captured.
module ilv_bank_slot #(
    parameter int RW  = 15,
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [RW-1:0] issue_row,
    input  logic          inval,
    input  logic [DW-1:0] rdata,
    output logic          held,
    output logic          ready,
    output logic [RW-1:0] tag,
    output logic [DW-1:0] data
);
    localparam int CNTW = $clog2(LAT + 1);

    logic            pend_q;
    logic            ready_q;
    logic [CNTW-1:0] cnt_q;
    logic [RW-1:0]   tag_q;
    logic [DW-1:0]   data_q;

    // Arm on issue, drop on invalidate, capture when the countdown ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            ready_q <= 1'b0;
            cnt_q   <= '0;
            tag_q   <= '0;
            data_q  <= '0;
        end else if (issue) begin
            pend_q  <= 1'b1;
            ready_q <= 1'b0;
            cnt_q   <= CNTW'(LAT);
            tag_q   <= issue_row;
        end else if (inval) begin
            pend_q  <= 1'b0;
            ready_q <= 1'b0;
        end else if (pend_q) begin
            if (cnt_q == CNTW'(1)) begin
                pend_q  <= 1'b0;
                ready_q <= 1'b1;
                data_q  <= rdata;
            end
            cnt_q <= cnt_q - CNTW'(1);
        end
    end

    assign held  = pend_q | ready_q;
    assign ready = ready_q;
    assign tag   = tag_q;
    assign data  = data_q;

    p_issue_arms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (pend_q && !ready_q && (tag_q == $past(issue_row))));

    p_inval_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inval && !issue) |=> !held);

    p_fill_from_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(pend_q));
endmodule

// File: rtl/ilv_issue.sv
// Command router.
// Turns one accepted request into per-bank read/write strobes and row
// addresses. It also decides whether the request hits a buffered word and
// whether a look-ahead of the next address is needed.
// Purely combinational; the caller gates it with request acceptance.
module ilv_issue #(
    parameter int AW = 16
) (
    input  logic                 acc,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic [1:0]           held,
    input  logic [1:0][AW-2:0]   tag,
    output logic [1:0]           rd_o,
    output logic [1:0]           wr_o,
    output logic [1:0][AW-2:0]   row_o,
    output logic [1:0]           inval_o,
    output logic                 hit
);
    localparam int RW = AW - 1;

    logic          tb;
    logic [RW-1:0] trow;
    logic [AW-1:0] nx;
    logic          nb;
    logic [RW-1:0] nrow;
    logic          la_need;

    // Target bank and row, and the next sequential word on the other bank.
    always_comb begin
        tb      = addr[0];
        trow    = addr[AW-1:1];
        nx      = addr + AW'(1);
        nb      = nx[0];
        nrow    = nx[AW-1:1];
        hit     = held[tb] && (tag[tb] == trow);
        la_need = !(held[nb] && (tag[nb] == nrow));
    end

    for (genvar b = 0; b < ilv_pkg::NBANK; b++) begin : g_bank
        // Per-bank strobes: the target bank gets the real access, the other the look-ahead.
        always_comb begin
            if (tb == 1'(b)) begin
                rd_o[b]    = acc && !wr && !hit;
                wr_o[b]    = acc && wr;
                row_o[b]   = trow;
                inval_o[b] = acc && wr && held[b] && (tag[b] == trow);
            end else begin
                rd_o[b]    = acc && !wr && la_need;
                wr_o[b]    = 1'b0;
                row_o[b]   = nrow;
                inval_o[b] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ilv_mem_ctrl.sv
// Two-bank interleaved read controller (top).
// Accepts one processor request at a time. It answers reads from a one-word
// per-bank buffer that is filled by look-ahead reads of the next sequential
// address on the opposite bank.
// Assumes: each bank accepts one command per cycle and returns read data
// exactly LAT cycles after the strobe; a write and a read never target
// the same bank in one cycle.
module ilv_mem_ctrl #(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int LAT = 2,
    parameter int CW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          b0_rd,
    output logic          b0_wr,
    output logic [AW-2:0] b0_addr,
    output logic [DW-1:0] b0_wdata,
    input  logic [DW-1:0] b0_rdata,
    output logic          b1_rd,
    output logic          b1_wr,
    output logic [AW-2:0] b1_addr,
    output logic [DW-1:0] b1_wdata,
    input  logic [DW-1:0] b1_rdata,
    output logic [CW-1:0] hit_count,
    output logic [CW-1:0] miss_count
);
    import ilv_pkg::*;

    localparam int RW = AW - 1;

    ilv_state_e          state_q;
    logic                pbank_q;
    logic [RW-1:0]       prow_q;

    logic                acc;
    logic                hit;
    logic [1:0]          bank_rd;
    logic [1:0]          bank_wr;
    logic [1:0][RW-1:0]  bank_row;
    logic [1:0]          slot_inval;
    logic [1:0]          slot_held;
    logic [1:0]          slot_ready;
    logic [1:0][RW-1:0]  slot_tag;
    logic [1:0][DW-1:0]  slot_data;
    logic [1:0][DW-1:0]  bank_rdata;

    assign req_ready = (state_q == ST_IDLE);
    assign acc       = req_valid && req_ready;

    ilv_issue #(.AW(AW)) u_issue (
        .acc     (acc),
        .wr      (req_write),
        .addr    (req_addr),
        .held    (slot_held),
        .tag     (slot_tag),
        .rd_o    (bank_rd),
        .wr_o    (bank_wr),
        .row_o   (bank_row),
        .inval_o (slot_inval),
        .hit     (hit)
    );

    assign bank_rdata[0] = b0_rdata;
    assign bank_rdata[1] = b1_rdata;

    for (genvar b = 0; b < NBANK; b++) begin : g_slot
        ilv_bank_slot #(.RW(RW), .DW(DW), .LAT(LAT)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue     (bank_rd[b]),
            .issue_row (bank_row[b]),
            .inval     (slot_inval[b]),
            .rdata     (bank_rdata[b]),
            .held      (slot_held[b]),
            .ready     (slot_ready[b]),
            .tag       (slot_tag[b]),
            .data      (slot_data[b])
        );

        p_cmd_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(bank_rd[b] && bank_wr[b]));
    end

    // Bank bus outputs.
    assign b0_rd    = bank_rd[0];
    assign b0_wr    = bank_wr[0];
    assign b0_addr  = bank_row[0];
    assign b0_wdata = req_wdata;
    assign b1_rd    = bank_rd[1];
    assign b1_wr    = bank_wr[1];
    assign b1_addr  = bank_row[1];
    assign b1_wdata = req_wdata;

    // The response fires when the awaited slot holds the awaited row with data.
    assign rsp_valid = (state_q == ST_WAIT) && slot_ready[pbank_q]
                       && (slot_tag[pbank_q] == prow_q);
    assign rsp_data  = slot_data[pbank_q];

    // Request sequencing: remember which word a read waits for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pbank_q <= 1'b0;
            prow_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (acc && !req_write) begin
                    state_q <= ST_WAIT;
                    pbank_q <= req_addr[0];
                    prow_q  <= req_addr[AW-1:1];
                end
                ST_WAIT: if (rsp_valid) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    ilv_sat_cnt #(.W(CW)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (acc && !req_write && hit),
        .q     (hit_count)
    );

    ilv_sat_cnt #(.W(CW)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (acc && !req_write && !hit),
        .q     (miss_count)
    );

    // Checker-side view of the next word, derived from the port address.
    logic [AW-1:0] chk_next;
    assign chk_next = req_addr + AW'(1);

    p_lookahead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write) |-> (bank_rd[chk_next[0]]
            || (slot_held[chk_next[0]] && (slot_tag[chk_next[0]] == chk_next[AW-1:1]))));

    p_write_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write) |-> (bank_rd == 2'b00));

    p_wait_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_hit_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && slot_ready[req_addr[0]]
            && (slot_tag[req_addr[0]] == req_addr[AW-1:1])) |=> rsp_valid);

    p_one_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write) |=> ((hit_count != $past(hit_count))
            || (miss_count != $past(miss_count))
            || (hit_count == '1) || (miss_count == '1)));
endmodule

// File: tb/ilv_mem_ctrl_bench.sv
module ilv_mem_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam int LAT = 3;
    localparam int CW  = 6;
    localparam int NROW = 1 << (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          b0_rd, b0_wr, b1_rd, b1_wr;
    logic [AW-2:0] b0_addr, b1_addr;
    logic [DW-1:0] b0_wdata, b1_wdata, b0_rdata, b1_rdata;
    logic [CW-1:0] hit_count, miss_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ilv_mem_ctrl #(.AW(AW), .DW(DW), .LAT(LAT), .CW(CW)) u_ilv_mem_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .b0_rd(b0_rd), .b0_wr(b0_wr), .b0_addr(b0_addr), .b0_wdata(b0_wdata), .b0_rdata(b0_rdata),
        .b1_rd(b1_rd), .b1_wr(b1_wr), .b1_addr(b1_addr), .b1_wdata(b1_wdata), .b1_rdata(b1_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Behavioural banks: fixed LAT-cycle read pipeline, writes land at the edge.
    logic [DW-1:0] mem0 [NROW];
    logic [DW-1:0] mem1 [NROW];
    logic [DW-1:0] pipe0 [LAT];
    logic [DW-1:0] pipe1 [LAT];

    initial begin
        for (int r = 0; r < NROW; r++) begin
            mem0[r] = {8'hB0, 8'h00, 8'(r), 8'(r * 3)};
            mem1[r] = {8'hB1, 8'h11, 8'(r), 8'(r * 5)};
        end
    end

    always @(posedge clk) begin
        if (b0_wr) mem0[b0_addr] <= b0_wdata;
        if (b1_wr) mem1[b1_addr] <= b1_wdata;
        pipe0[0] <= b0_rd ? mem0[b0_addr] : 32'hDEAD_0000;
        pipe1[0] <= b1_rd ? mem1[b1_addr] : 32'hDEAD_1111;
        for (int k = 1; k < LAT; k++) begin
            pipe0[k] <= pipe0[k-1];
            pipe1[k] <= pipe1[k-1];
        end
    end
    assign b0_rdata = pipe0[LAT-1];
    assign b1_rdata = pipe1[LAT-1];

    function automatic logic [DW-1:0] bank_word(input logic [AW-1:0] a);
        return a[0] ? mem1[a[AW-1:1]] : mem0[a[AW-1:1]];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Issue one read; report latency, data, bank strobes in the acceptance cycle.
    task automatic do_read(input logic [AW-1:0] a, output int lat, output logic [DW-1:0] d,
                           output logic [1:0] rd, output logic [1:0][AW-2:0] row,
                           output bit ready_ok);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd  = {b1_rd, b0_rd};
        row = {b1_addr, b0_addr};
        @(posedge clk); #1;
        req_valid = 1'b0;
        lat = 0; ready_ok = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            if (req_ready) ready_ok = 1'b0;
        end while (!rsp_valid && lat < 40);
        d = rsp_data;
    endtask

    // Read with latency and data checks; miss = latency LAT+1.
    task automatic read_chk(input logic [AW-1:0] a, input int exp_lat, input string req);
        int lat; logic [DW-1:0] d; logic [1:0] rd; logic [1:0][AW-2:0] row; bit rok;
        logic [DW-1:0] exp_d;
        exp_d = bank_word(a);
        do_read(a, lat, d, rd, row, rok);
        check(lat == exp_lat, req, "latency", lat, exp_lat);
        check(d == exp_d, req, "data", d, exp_d);
        check(rok, "R4", "req_ready low while waiting", rok, 1);
    endtask

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [3:0]    lat;
        logic          la;
    } vec_t;

    // Alternating, in-flight, cancel, same-bank, repeat and wrap cases (LAT=3: miss=4).
    localparam vec_t VEC [13] = '{
        '{8'h10, 4'd4, 1'b1},
        '{8'h11, 4'd1, 1'b1},
        '{8'h12, 4'd2, 1'b1},
        '{8'h13, 4'd1, 1'b1},
        '{8'h14, 4'd2, 1'b1},
        '{8'h17, 4'd4, 1'b1},
        '{8'h19, 4'd4, 1'b1},
        '{8'h1B, 4'd4, 1'b1},
        '{8'h1C, 4'd1, 1'b1},
        '{8'h1C, 4'd1, 1'b0},
        '{8'h1D, 4'd1, 1'b1},
        '{8'hFF, 4'd4, 1'b1},
        '{8'h00, 4'd1, 1'b1}
    };

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R10", "rsp_valid", rsp_valid, 0);
        check(hit_count == 0 && miss_count == 0, "R10", "counters",
              {hit_count, miss_count}, 0);
        check({b0_rd, b0_wr, b1_rd, b1_wr} == 4'b0, "R10", "bank strobes",
              {b0_rd, b0_wr, b1_rd, b1_wr}, 0);

        for (int i = 0; i < 13; i++) begin
            int lat; logic [DW-1:0] d; logic [1:0] rd; logic [1:0][AW-2:0] row; bit rok;
            logic [AW-1:0] a, nx; logic [DW-1:0] exp_d; bit miss; string rq;
            a = VEC[i].addr; nx = a + 8'd1; exp_d = bank_word(a);
            miss = (int'(VEC[i].lat) == LAT + 1);
            do_read(a, lat, d, rd, row, rok);
            rq = miss ? ((i == 5) ? "R11" : ((i == 6 || i == 7) ? "R7" : "R4"))
                      : ((VEC[i].lat == 4'd2) ? "R6" : "R5");
            check(lat == int'(VEC[i].lat), rq, "latency", lat, VEC[i].lat);
            check(d == exp_d, rq, "data", d, exp_d);
            check(rok, "R4", "req_ready low while waiting", rok, 1);
            check(rd[a[0]] == miss, "R1", "target bank strobe", rd[a[0]], miss);
            if (miss) check(row[a[0]] == a[AW-1:1], "R1", "target row", row[a[0]], a[AW-1:1]);
            check(rd[nx[0]] == VEC[i].la, "R3", "look-ahead strobe", rd[nx[0]], VEC[i].la);
            if (VEC[i].la) check(row[nx[0]] == nx[AW-1:1], "R3", "look-ahead row",
                                 row[nx[0]], nx[AW-1:1]);
            if (miss && VEC[i].la) check(rd == 2'b11, "R2", "both banks busy", rd, 3);
        end
        @(negedge clk);
        check(hit_count == 8, "R9", "hit count after table", hit_count, 8);
        check(miss_count == 5, "R9", "miss count after table", miss_count, 5);

        // R8: write drops the buffered look-ahead word
        read_chk(8'h20, LAT + 1, "R8");
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h21; req_wdata = 32'h1234_5678;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        check(b1_wr && b1_addr == 7'h10 && b1_wdata == 32'h1234_5678, "R8", "bank1 write",
              {b1_wr, b1_addr}, {1'b1, 7'h10});
        check(!b0_rd && !b1_rd && !b0_wr, "R8", "no read on write", {b0_rd, b1_rd, b0_wr}, 0);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(!rsp_valid && req_ready, "R8", "no response to write", rsp_valid, 0);
        end
        read_chk(8'h21, LAT + 1, "R8");
        @(negedge clk);
        check(miss_count == 7 && hit_count == 8, "R9", "counts after write test",
              {hit_count, miss_count}, {6'd8, 6'd7});

        // R9: saturate the hit counter with an alternating stream
        for (int k = 0; k < 60; k++) begin
            int lat; logic [DW-1:0] d; logic [1:0] rd; logic [1:0][AW-2:0] row; bit rok;
            do_read(8'h40 + 8'(k), lat, d, rd, row, rok);
        end
        @(negedge clk);
        check(hit_count == 6'h3F, "R9", "hit saturated", hit_count, 6'h3F);
        check(miss_count == 8, "R9", "miss after alternating", miss_count, 8);

        // R7/R9: same-bank stream always misses and saturates the miss counter
        for (int k = 0; k < 60; k++) begin
            read_chk(8'h80 + 8'(2 * k), LAT + 1, "R7");
        end
        @(negedge clk);
        check(miss_count == 6'h3F, "R9", "miss saturated", miss_count, 6'h3F);
        check(hit_count == 6'h3F, "R9", "hit held", hit_count, 6'h3F);

        // R10: reset mid-run clears counters and the buffer
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(hit_count == 0 && miss_count == 0, "R10", "counters after reset",
              {hit_count, miss_count}, 0);
        check(req_ready && !rsp_valid, "R10", "handshake after reset", {req_ready, rsp_valid}, 2);
        read_chk(8'h81, LAT + 1, "R10");

        summary();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule